// File: doc/BRIEF.md
# TMC Response Send Controller

This block answers a host's request for data under the USB Test and Measurement Class. The device side never starts a transfer. The block stays idle until a request header arrives that is correctly formed. It then shows the application the largest byte count the host will accept. Next it waits for the application to commit a response length and to fill a 32-bit send FIFO.

Once a length is committed, the block streams a 12-byte response header to the transport as three 32-bit words. It then forwards FIFO words until the committed number of bytes has gone out, and gives a one-cycle completion pulse before it returns to idle. A payload that does not end on a 4-byte boundary is padded up to a whole word; the header reports only the committed byte count. The application's "more data follows" input becomes the end-of-message bit of the header. A host abort empties the FIFO and sends the block straight back to idle.

Top module: `tmc_resp_sender`

## Requirements
- R1: While idle, a request is accepted only when `req_msg_id` equals 2, `req_tag` is nonzero and `req_tag_inv` equals the bitwise inverse of `req_tag`. One cycle after an accepted `req_valid`, `data_req` is 1 and `max_bytes` holds `req_max`. Any other request leaves `data_req` at 0.
- R2: A request presented while a request is already being served is ignored: `max_bytes` and the tag used in the header do not change.
- R3: While `data_req` is 1, a `size_en` pulse latches the committed length min(`size_in`, `max_bytes`), samples `more_data`, and clears `data_req` on the following cycle.
- R4: The response header is three words, with header byte k in bits [8*(k mod 4)+7 : 8*(k mod 4)] of word k/4. Byte 0 is 2, byte 1 is the tag, byte 2 is the inverted tag, byte 3 is 0. Bytes 4 to 7 hold the committed length, least significant byte first. Bit 0 of byte 8 is the end-of-message flag, equal to the inverse of `more_data` at the latch. All other bits are 0.
- R5: After the header, exactly ceil(committed/4) FIFO words are sent in the order they were written. A committed length of 0 sends the header only.
- R6: A word is transferred on a cycle where `tx_valid` and `tx_ready` are both 1. While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` keeps its value.
- R7: `finished` pulses for exactly one cycle after the last word is accepted, and the block is then idle and accepts a new request.
- R8: `abort` sends the block to idle on the next cycle and empties the send FIFO. `finished` does not pulse, and `data_req` and `tx_valid` are 0.
- R9: A FIFO write is stored only while a request is open (from request acceptance to the last word) and the FIFO is not full. `fifo_full` is 1 when FIFO_DEPTH words are held.
- R10: `data_req` and `tx_valid` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | A parsed request header is present this cycle |
| req_msg_id | input | 8 | Message identifier field of the request |
| req_tag | input | 8 | Tag field of the request |
| req_tag_inv | input | 8 | Inverted-tag field of the request |
| req_max | input | 32 | Maximum response length in bytes allowed by the host |
| data_req | output | 1 | A request is open and waiting for a committed length |
| max_bytes | output | 32 | Maximum response length of the open request |
| size_en | input | 1 | Commit strobe for `size_in` |
| size_in | input | 32 | Response length in bytes offered by the application |
| more_data | input | 1 | Further transfers will follow this one |
| fifo_wr_en | input | 1 | Send FIFO write enable |
| fifo_wdata | input | 32 | Send FIFO write data |
| fifo_full | output | 1 | Send FIFO is full |
| tx_valid | output | 1 | `tx_data` holds a word for the transport |
| tx_ready | input | 1 | Transport accepts the word this cycle |
| tx_data | output | 32 | Header or payload word |
| abort | input | 1 | Host abort: flush and return to idle |
| finished | output | 1 | One-cycle pulse when the response is complete |

## Verification
The hardest state to reach is a full FIFO while a request is still open. The bench gets there by accepting a request and then writing one word more than the FIFO depth before committing a length. It then checks that the extra word was dropped and that a word written after draining begins takes its place. An abort is hard to observe from outside. To observe one, the bench holds `tx_ready` low so that words stay in the FIFO, aborts, and runs a fresh transfer; that transfer must carry only new words, which shows the flush happened. A sweep over committed lengths 0 to 20 against several host maxima covers clamping, padding and the zero-length header.

// File: rtl/tmc_tx_pkg.sv
package tmc_tx_pkg;

  localparam int WORD_W    = 32;
  localparam int HDR_WORDS = 3;

  // message id used both to recognise a request and to mark the response
  localparam logic [7:0] MSG_ID_IN = 8'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HDR,
    ST_BODY,
    ST_DONE
  } tx_state_e;

endpackage

// File: rtl/tmc_tx_fifo.sv
module tmc_tx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         rd_en,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_do, rd_do;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_do = wr_en && !full && !flush;
  assign rd_do = rd_en && !empty && !flush;
  assign rdata = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (wr_do) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (rd_do) rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({wr_do, rd_do})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_do) mem[wr_ptr_q] <= wdata;
  end

endmodule

// File: rtl/tmc_tx_hdr.sv
module tmc_tx_hdr #(
  parameter int SIZE_W = 32
) (
  input  logic [1:0]        idx,
  input  logic [7:0]        tag,
  input  logic [SIZE_W-1:0] size,
  input  logic              eom,
  output logic [31:0]       word
);
  import tmc_tx_pkg::*;

  logic [31:0] w0, w1, w2;

  assign w0 = {8'h00, ~tag, tag, MSG_ID_IN};
  assign w1 = 32'(size);
  assign w2 = {31'b0, eom};

  always_comb begin
    case (idx)
      2'd0:    word = w0;
      2'd1:    word = w1;
      default: word = w2;
    endcase
  end

endmodule

// File: rtl/tmc_tx_ctrl.sv
module tmc_tx_ctrl #(
  parameter int SIZE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [7:0]        req_msg_id,
  input  logic [7:0]        req_tag,
  input  logic [7:0]        req_tag_inv,
  input  logic [SIZE_W-1:0] req_max,
  input  logic              size_en,
  input  logic [SIZE_W-1:0] size_in,
  input  logic              more_data,
  input  logic              abort,
  input  logic              tx_ready,
  input  logic              fifo_empty,
  output logic              data_req,
  output logic [SIZE_W-1:0] max_bytes,
  output logic [7:0]        tag,
  output logic [SIZE_W-1:0] size,
  output logic              eom,
  output logic [1:0]        hdr_idx,
  output logic              hdr_phase,
  output logic              body_phase,
  output logic              pop,
  output logic              wr_allow,
  output logic              finished
);
  import tmc_tx_pkg::*;

  localparam int CNT_W = SIZE_W - 1;
  localparam logic [1:0] HDR_LAST = 2'(HDR_WORDS - 1);

  tx_state_e         state_q, state_d;
  logic [SIZE_W-1:0] max_q, size_q;
  logic [7:0]        tag_q;
  logic              eom_q;
  logic [CNT_W-1:0]  words_q, words_d;
  logic [1:0]        idx_q, idx_d;
  logic              req_ok, ld_req, ld_size, words_en, idx_en;
  logic [SIZE_W-1:0] clamped;
  logic [SIZE_W:0]   padded;

  assign req_ok  = req_valid && (req_msg_id == MSG_ID_IN) &&
                   (req_tag != 8'h00) && (req_tag_inv == ~req_tag);
  assign clamped = (size_in > max_q) ? max_q : size_in;
  assign padded  = {1'b0, clamped} + (SIZE_W+1)'(3);

  assign ld_req  = (state_q == ST_IDLE) && req_ok && !abort;
  assign ld_size = (state_q == ST_WAIT) && size_en && !abort;
  assign pop     = (state_q == ST_BODY) && tx_ready && !fifo_empty && !abort;

  always_comb begin
    state_d  = state_q;
    words_d  = words_q;
    idx_d    = idx_q;
    words_en = 1'b0;
    idx_en   = 1'b0;
    case (state_q)
      ST_IDLE: if (req_ok) state_d = ST_WAIT;
      ST_WAIT: begin
        if (size_en) begin
          state_d  = ST_HDR;
          words_d  = padded[SIZE_W:2];
          words_en = 1'b1;
          idx_d    = '0;
          idx_en   = 1'b1;
        end
      end
      ST_HDR: begin
        if (tx_ready) begin
          if (idx_q == HDR_LAST) begin
            state_d = (words_q == '0) ? ST_DONE : ST_BODY;
          end else begin
            idx_d  = idx_q + 1'b1;
            idx_en = 1'b1;
          end
        end
      end
      ST_BODY: begin
        if (pop) begin
          words_d  = words_q - 1'b1;
          words_en = 1'b1;
          if (words_q == CNT_W'(1)) state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (abort) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q <= '0;
      tag_q <= '0;
    end else if (ld_req) begin
      max_q <= req_max;
      tag_q <= req_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      eom_q  <= 1'b0;
    end else if (ld_size) begin
      size_q <= clamped;
      eom_q  <= !more_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        words_q <= '0;
    else if (words_en) words_q <= words_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign data_req   = (state_q == ST_WAIT);
  assign max_bytes  = max_q;
  assign tag        = tag_q;
  assign size       = size_q;
  assign eom        = eom_q;
  assign hdr_idx    = idx_q;
  assign hdr_phase  = (state_q == ST_HDR);
  assign body_phase = (state_q == ST_BODY);
  assign wr_allow   = (state_q == ST_WAIT) || (state_q == ST_HDR) ||
                      (state_q == ST_BODY);
  assign finished   = (state_q == ST_DONE);

endmodule

// File: rtl/tmc_resp_sender.sv
module tmc_resp_sender #(
  parameter int FIFO_DEPTH = 8,
  parameter int SIZE_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [7:0]        req_msg_id,
  input  logic [7:0]        req_tag,
  input  logic [7:0]        req_tag_inv,
  input  logic [SIZE_W-1:0] req_max,
  output logic              data_req,
  output logic [SIZE_W-1:0] max_bytes,
  input  logic              size_en,
  input  logic [SIZE_W-1:0] size_in,
  input  logic              more_data,
  input  logic              fifo_wr_en,
  input  logic [31:0]       fifo_wdata,
  output logic              fifo_full,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [31:0]       tx_data,
  input  logic              abort,
  output logic              finished
);
  import tmc_tx_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic [7:0]        tag;
  logic [SIZE_W-1:0] size;
  logic              eom;
  logic [1:0]        hdr_idx;
  logic              hdr_phase, body_phase, pop, wr_allow;
  logic              fifo_empty;
  logic [WORD_W-1:0] fifo_rdata, hdr_word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  tmc_tx_ctrl #(.SIZE_W(SIZE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .req_valid  (req_valid),
    .req_msg_id (req_msg_id),
    .req_tag    (req_tag),
    .req_tag_inv(req_tag_inv),
    .req_max    (req_max),
    .size_en    (size_en),
    .size_in    (size_in),
    .more_data  (more_data),
    .abort      (abort),
    .tx_ready   (tx_ready),
    .fifo_empty (fifo_empty),
    .data_req   (data_req),
    .max_bytes  (max_bytes),
    .tag        (tag),
    .size       (size),
    .eom        (eom),
    .hdr_idx    (hdr_idx),
    .hdr_phase  (hdr_phase),
    .body_phase (body_phase),
    .pop        (pop),
    .wr_allow   (wr_allow),
    .finished   (finished)
  );

  tmc_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n_i),
    .flush (abort),
    .wr_en (fifo_wr_en && wr_allow),
    .wdata (fifo_wdata),
    .rd_en (pop),
    .rdata (fifo_rdata),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  tmc_tx_hdr #(.SIZE_W(SIZE_W)) u_hdr (
    .idx (hdr_idx),
    .tag (tag),
    .size(size),
    .eom (eom),
    .word(hdr_word)
  );

  assign tx_valid = hdr_phase || (body_phase && !fifo_empty);
  assign tx_data  = hdr_phase ? hdr_word : fifo_rdata;

endmodule

// File: rtl/tmc_resp_sender_chk.sv
module tmc_resp_sender_chk #(
  parameter int SIZE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              data_req,
  input logic [SIZE_W-1:0] max_bytes,
  input logic              size_en,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [31:0]       tx_data,
  input logic              abort,
  input logic              finished
);

  // R10
  req_tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_req && tx_valid));

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !abort) |=> (tx_valid && $stable(tx_data)));

  // R7
  fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finished |=> !finished);

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!finished && !data_req && !tx_valid));

  // R2
  max_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_req && !size_en && !abort) |=> (data_req && $stable(max_bytes)));

endmodule

bind tmc_resp_sender tmc_resp_sender_chk #(.SIZE_W(SIZE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .data_req (data_req),
  .max_bytes(max_bytes),
  .size_en  (size_en),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .abort    (abort),
  .finished (finished)
);

// File: tb/tmc_resp_sender_bench.sv
`timescale 1ns/1ps
module tmc_resp_sender_bench;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [7:0]  req_msg_id, req_tag, req_tag_inv;
  logic [31:0] req_max;
  logic        data_req;
  logic [31:0] max_bytes;
  logic        size_en;
  logic [31:0] size_in;
  logic        more_data;
  logic        fifo_wr_en;
  logic [31:0] fifo_wdata;
  logic        fifo_full;
  logic        tx_valid;
  logic        tx_ready;
  logic [31:0] tx_data;
  logic        abort;
  logic        finished;

  int tests = 0;
  int fails = 0;
  int ncap  = 0;
  int fin_cnt = 0;
  int stall_mode = 0;
  int cyc = 0;
  logic [31:0] cap [32];

  always #4 clk = ~clk;

  tmc_resp_sender #(.FIFO_DEPTH(DEPTH), .SIZE_W(32)) u_tmc_resp_sender (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_msg_id(req_msg_id),
    .req_tag(req_tag), .req_tag_inv(req_tag_inv), .req_max(req_max),
    .data_req(data_req), .max_bytes(max_bytes), .size_en(size_en),
    .size_in(size_in), .more_data(more_data), .fifo_wr_en(fifo_wr_en),
    .fifo_wdata(fifo_wdata), .fifo_full(fifo_full), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .abort(abort), .finished(finished)
  );

  // transport ready pattern, driven just after each rising edge
  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    if (stall_mode == 2)      tx_ready = 1'b0;
    else if (stall_mode == 1) tx_ready = (cyc % 3 != 1);
    else                      tx_ready = 1'b1;
  end

  // capture accepted words and completion pulses away from the edge
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (ncap < 32) cap[ncap] = tx_data;
      ncap = ncap + 1;
    end
    if (rst_n && finished) fin_cnt = fin_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send_req(input logic [7:0] id, input logic [7:0] tg,
                          input logic [7:0] tinv, input logic [31:0] mx);
    req_msg_id = id; req_tag = tg; req_tag_inv = tinv; req_max = mx;
    req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
  endtask

  task automatic wait_fin(input int f0);
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      if (fin_cnt != f0) break;
    end
    tick(); tick();
  endtask

  task automatic run_xfer(input logic [31:0] mx, input logic [31:0] sz,
                          input bit more, input logic [7:0] tg, input int stall,
                          input bit dup, input logic [31:0] base);
    logic [31:0] commit;
    int n, f0;
    ncap = 0; f0 = fin_cnt; stall_mode = stall;
    send_req(8'd2, tg, ~tg, mx);
    @(negedge clk);
    check(data_req === 1'b1, "R1 data_req on valid request", 32'(data_req), 1);
    check(max_bytes === mx, "R1 max_bytes", max_bytes, mx);
    check(tx_valid === 1'b0, "R10 no tx while requesting", 32'(tx_valid), 0);
    if (dup) begin
      tick();
      send_req(8'd2, tg ^ 8'h5A, ~(tg ^ 8'h5A), mx + 7);
      @(negedge clk);
      check(max_bytes === mx, "R2 second request ignored", max_bytes, mx);
    end
    commit = (sz > mx) ? mx : sz;
    n = int'((commit + 3) / 4);
    tick();
    size_in = sz; more_data = more; size_en = 1'b1;
    tick();
    size_en = 1'b0;
    @(negedge clk);
    check(data_req === 1'b0, "R3 data_req clears after size latch", 32'(data_req), 0);
    tick();
    for (int i = 0; i < n; i++) begin
      while (fifo_full) tick();
      fifo_wr_en = 1'b1; fifo_wdata = base + 32'(i);
      tick();
      fifo_wr_en = 1'b0;
    end
    wait_fin(f0);
    check(fin_cnt == f0 + 1, "R7 one finished pulse", 32'(fin_cnt - f0), 1);
    check(ncap == 3 + n, "R5 word count", 32'(ncap), 32'(3 + n));
    check(cap[0] == {8'h00, ~tg, tg, 8'h02}, "R4 header word 0", cap[0],
          {8'h00, ~tg, tg, 8'h02});
    check(cap[1] == commit, "R3 R4 committed length clamp", cap[1], commit);
    check(cap[2] == {31'b0, !more}, "R4 end-of-message bit", cap[2], {31'b0, !more});
    for (int i = 0; i < n && i < 29; i++) begin
      if (stall == 1)
        check(cap[3+i] == base + 32'(i), "R6 payload order under stalls",
              cap[3+i], base + 32'(i));
      else
        check(cap[3+i] == base + 32'(i), "R5 payload order", cap[3+i], base + 32'(i));
    end
    stall_mode = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests = tests + 1;
    fails = fails + 1;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] mxs [5];
    int run, f0;
    mxs[0] = 0; mxs[1] = 5; mxs[2] = 8; mxs[3] = 13; mxs[4] = 16;
    rst_n = 1'b0; req_valid = 1'b0; req_msg_id = '0; req_tag = '0;
    req_tag_inv = '0; req_max = '0; size_en = 1'b0; size_in = '0;
    more_data = 1'b0; fifo_wr_en = 1'b0; fifo_wdata = '0; abort = 1'b0;
    tx_ready = 1'b1;
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    @(negedge clk);
    check(data_req === 1'b0, "R1 reset data_req", 32'(data_req), 0);
    check(tx_valid === 1'b0, "R10 reset tx_valid", 32'(tx_valid), 0);
    check(finished === 1'b0, "R7 reset finished", 32'(finished), 0);
    check(fifo_full === 1'b0, "R9 reset fifo_full", 32'(fifo_full), 0);

    // malformed requests
    tick();
    send_req(8'd3, 8'd5, ~8'd5, 32'd10);
    @(negedge clk);
    check(data_req === 1'b0, "R1 wrong message id ignored", 32'(data_req), 0);
    tick();
    send_req(8'd2, 8'd5, 8'd5, 32'd10);
    @(negedge clk);
    check(data_req === 1'b0, "R1 bad inverted tag ignored", 32'(data_req), 0);
    tick();
    send_req(8'd2, 8'd0, 8'hFF, 32'd10);
    @(negedge clk);
    check(data_req === 1'b0, "R1 zero tag ignored", 32'(data_req), 0);
    tick();

    // sweep committed length against several host maxima
    run = 0;
    for (int m = 0; m < 5; m++) begin
      for (int s = 0; s <= 20; s++) begin
        run_xfer(mxs[m], 32'(s), bit'(s % 2), 8'((run % 255) + 1), run % 2,
                 (s == 7), 32'hA500_0000 + 32'(run * 64));
        run = run + 1;
      end
    end

    // abort with words left in the FIFO, then write while idle
    f0 = fin_cnt; stall_mode = 2;
    send_req(8'd2, 8'd7, ~8'd7, 32'd16);
    tick();
    size_in = 32'd16; more_data = 1'b0; size_en = 1'b1;
    tick();
    size_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      fifo_wr_en = 1'b1; fifo_wdata = 32'hBAD0_0000 + 32'(i);
      tick();
    end
    fifo_wr_en = 1'b0;
    abort = 1'b1;
    tick();
    abort = 1'b0;
    stall_mode = 0;
    @(negedge clk);
    check(data_req === 1'b0, "R8 data_req low after abort", 32'(data_req), 0);
    check(tx_valid === 1'b0, "R8 tx_valid low after abort", 32'(tx_valid), 0);
    tick(); tick();
    check(fin_cnt == f0, "R8 no finished on abort", 32'(fin_cnt - f0), 0);
    fifo_wr_en = 1'b1; fifo_wdata = 32'hDEAD_BEEF;
    tick();
    fifo_wr_en = 1'b0;
    tick();
    ncap = 0;
    run_xfer(32'd8, 32'd4, 1'b0, 8'd33, 0, 1'b0, 32'h1234_0000);
    check(cap[3] == 32'h1234_0000, "R8 R9 flushed and idle write dropped",
          cap[3], 32'h1234_0000);

    // fill the FIFO past its depth while the request is open
    ncap = 0; f0 = fin_cnt;
    send_req(8'd2, 8'd44, ~8'd44, 32'd64);
    tick();
    for (int i = 0; i <= DEPTH; i++) begin
      fifo_wr_en = 1'b1; fifo_wdata = 32'hF000_0000 + 32'(i);
      tick();
    end
    fifo_wr_en = 1'b0;
    @(negedge clk);
    check(fifo_full === 1'b1, "R9 fifo_full at depth", 32'(fifo_full), 1);
    tick();
    size_in = 32'(4 * (DEPTH + 1)); more_data = 1'b1; size_en = 1'b1;
    tick();
    size_en = 1'b0;
    while (fifo_full) tick();
    fifo_wr_en = 1'b1; fifo_wdata = 32'hF000_00FF;
    tick();
    fifo_wr_en = 1'b0;
    wait_fin(f0);
    check(ncap == 3 + DEPTH + 1, "R9 word count after overflow", 32'(ncap),
          32'(3 + DEPTH + 1));
    check(cap[2] == 32'd0, "R4 more data clears end-of-message", cap[2], 0);
    check(cap[3 + DEPTH - 1] == 32'hF000_0000 + 32'(DEPTH - 1), "R9 last stored word",
          cap[3 + DEPTH - 1], 32'hF000_0000 + 32'(DEPTH - 1));
    check(cap[3 + DEPTH] == 32'hF000_00FF, "R9 write while full dropped",
          cap[3 + DEPTH], 32'hF000_00FF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule